// File: doc/BRIEF.md
# SPI receive status flag unit

This block keeps the receive-side and fault status flags of a 16-bit SPI peripheral as a CPU sees them. It takes one-cycle word strobes and data from a serial shifter, CPU bus strobes (status read, data read, status write with a write byte, control-register-1 write), a 16-bit compare value and the master/slave configuration bits with the slave-select input. It drives three flags: receive-full, match and mode-fault. It also drives the word returned by a data-register read.

With the FIFO mode off, a single receive buffer holds the most recent word. The receive-full flag then means that unread data is present. With the FIFO mode on, received words queue in a four-word (64-bit) store. The flag then rises only on the word that fills that store, and each data read returns and removes the oldest word. Each flag clears through its own bus sequence. The receive flag clears on a data read. The match flag needs a status read while it is set, then a write of 1 to bit 6 of the status register. The mode-fault flag needs a status read while it is set, then a control-register-1 write. Inputs are taken as already synchronous to `clk`.

Top module: `spi_rx_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, all flags, armed states, stored words and the word count are cleared, and `rd_data` reads 0 after that edge.
- R2: With `fifo_mode`=0, a `rx_valid` strobe stores `rx_data` in the single buffer, overwriting any earlier word. `rx_full` is 1 and `rd_data` shows the word from the next cycle on.
- R3: A `bus_rd_data` strobe clears `rx_full` at the next edge, unless the same cycle sets the flag again. In that case the flag stays 1. In single-buffer mode the buffered word stays visible on `rd_data`.
- R4: With `fifo_mode`=1, words are kept in arrival order, and `rd_data` shows the oldest. `rx_full` rises only at the edge that stores the fourth word. A `bus_rd_data` strobe removes the oldest word when the store is not empty.
- R5: With `fifo_mode`=1, a word that arrives while four words are held, with no data read in the same cycle, is discarded.
- R6: The match flag sets at the same edge at which `rx_full` is set by an arriving word, and only if that word equals `match_val`. No other event sets it.
- R7: The match flag clears only on a status write with bit 6 of `bus_wdata` at 1 that follows a status read made while the flag was 1. Any status write consumes that armed read, and a write without an armed read has no effect.
- R8: A match-set event between the arming status read and the clearing write discards the armed state. The following write then leaves the flag at 1.
- R9: `fault_flag` sets when `cfg_master`=1, `cfg_fault_en`=1, `cfg_ss_drive`=0 and `ss_in_n`=0. It never sets under any other combination.
- R10: `fault_flag` clears on a `bus_wr_ctrl` strobe that follows a status read made while it was 1. A control write without that read has no effect. A cycle in which the fault condition holds keeps the flag set and discards the armed state.
- R11: A change of `fifo_mode` empties the stored words, clears `rx_full` at the next edge and ignores that cycle's receive strobe and data read. `rd_data` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: shifter delivered a word |
| rx_data | input | 16 | Word from the shifter |
| bus_rd_status | input | 1 | CPU reads the status register |
| bus_rd_data | input | 1 | CPU reads the data register |
| bus_wr_status | input | 1 | CPU writes the status register |
| bus_wdata | input | 8 | Status write byte; bit 6 is the match-clear bit |
| bus_wr_ctrl | input | 1 | CPU writes control register 1 |
| match_val | input | 16 | Compare value |
| fifo_mode | input | 1 | 1 selects the four-word receive store |
| cfg_master | input | 1 | Block is configured as master |
| cfg_fault_en | input | 1 | Mode-fault detection enabled |
| cfg_ss_drive | input | 1 | Block drives slave-select as an output |
| ss_in_n | input | 1 | Slave-select input, active low |
| rx_full | output | 1 | Receive-full flag |
| match_flag | output | 1 | Match flag |
| fault_flag | output | 1 | Mode-fault flag |
| rd_data | output | 16 | Word returned by a data-register read |

## Verification
Directed sequences drive single-buffer overwrites, data reads that coincide with arrivals, a FIFO filled past four words and drained in order, and mode toggles with data present. These separate the two meanings of the receive flag and show the overflow drop and the flush. The clear sequences are tried in their valid and broken orders: write with no prior read, read then write with the wrong bit, and a set event between read and write. These show that each flag honours only its own arming path. The mode-fault condition is walked through all sixteen configuration combinations with slave-select low and high. Long random runs then mix every strobe with rare resets and mode flips, and compare each output each cycle with a bench model.

// File: rtl/spi_rx_status.sv
module spi_rx_status #(
  parameter int DW        = 16,
  parameter int FIFO_BITS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          bus_rd_status,
  input  logic          bus_rd_data,
  input  logic          bus_wr_status,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_wr_ctrl,
  input  logic [DW-1:0] match_val,
  input  logic          fifo_mode,
  input  logic          cfg_master,
  input  logic          cfg_fault_en,
  input  logic          cfg_ss_drive,
  input  logic          ss_in_n,
  output logic          rx_full,
  output logic          match_flag,
  output logic          fault_flag,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH     = FIFO_BITS / DW;
  localparam int CW        = $clog2(DEPTH + 1);
  localparam int MATCH_BIT = 6;

  logic [DW-1:0] q   [DEPTH];
  logic [DW-1:0] q_n [DEPTH];
  logic [CW-1:0] cnt, cnt_n;
  logic mode_q, full_q, mat_q, marm_q, flt_q, farm_q;
  logic set_evt;

  wire flush      = fifo_mode != mode_q;
  wire pop        = fifo_mode && bus_rd_data && (cnt != '0);
  wire room       = (cnt != CW'(DEPTH)) || pop;
  wire acc        = rx_valid && !flush && (!fifo_mode || room);
  wire match_set  = set_evt && (rx_data == match_val);
  wire fault_cond = cfg_master && cfg_fault_en && !cfg_ss_drive && !ss_in_n;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) q_n[i] = q[i];
    cnt_n   = cnt;
    set_evt = 1'b0;
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) q_n[i] = '0;
      cnt_n = '0;
    end else if (!fifo_mode) begin
      if (acc) begin
        q_n[0]  = rx_data;
        cnt_n   = CW'(1);
        set_evt = 1'b1;
      end else if (bus_rd_data) begin
        cnt_n = '0;
      end
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) q_n[i] = q[i+1];
        q_n[DEPTH-1] = '0;
        cnt_n = cnt - CW'(1);
      end
      if (acc) begin
        q_n[cnt_n] = rx_data;
        cnt_n      = cnt_n + CW'(1);
        set_evt    = (cnt_n == CW'(DEPTH));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      cnt    <= '0;
      mode_q <= fifo_mode;
      full_q <= 1'b0;
      mat_q  <= 1'b0;
      marm_q <= 1'b0;
      flt_q  <= 1'b0;
      farm_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) q[i] <= q_n[i];
      cnt    <= cnt_n;
      mode_q <= fifo_mode;
      full_q <= flush ? 1'b0 : set_evt ? 1'b1 : bus_rd_data ? 1'b0 : full_q;

      if (match_set)
        mat_q <= 1'b1;
      else if (bus_wr_status && bus_wdata[MATCH_BIT] && marm_q)
        mat_q <= 1'b0;
      marm_q <= match_set ? 1'b0 : (bus_rd_status && mat_q) ? 1'b1 :
                bus_wr_status ? 1'b0 : marm_q;

      if (fault_cond)
        flt_q <= 1'b1;
      else if (bus_wr_ctrl && farm_q)
        flt_q <= 1'b0;
      farm_q <= fault_cond ? 1'b0 : (bus_rd_status && flt_q) ? 1'b1 :
                bus_wr_ctrl ? 1'b0 : farm_q;
    end
  end

  assign rx_full    = full_q;
  assign match_flag = mat_q;
  assign fault_flag = flt_q;
  assign rd_data    = q[0];
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic bus_rd_data,
  input logic bus_wr_status,
  input logic wr_bit,
  input logic bus_wr_ctrl,
  input logic cfg_master,
  input logic cfg_fault_en,
  input logic cfg_ss_drive,
  input logic ss_in_n,
  input logic flush,
  input logic rx_full,
  input logic match_flag,
  input logic fault_flag
);
  p_rx_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) && $past(rst_n) |-> $past(rx_valid));

  p_rx_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) && $past(rst_n) |-> $past(bus_rd_data || flush));

  p_match_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) && $past(rst_n) |-> rx_full);

  p_match_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(match_flag) && $past(rst_n) |-> $past(bus_wr_status && wr_bit));

  p_fault_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) && $past(rst_n) |->
      $past(cfg_master && cfg_fault_en && !cfg_ss_drive && !ss_in_n));

  p_fault_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) && $past(rst_n) |-> $past(bus_wr_ctrl));

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rx_full);
endmodule

bind spi_rx_status spi_rx_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .bus_rd_data(bus_rd_data),
  .bus_wr_status(bus_wr_status), .wr_bit(bus_wdata[6]), .bus_wr_ctrl(bus_wr_ctrl),
  .cfg_master(cfg_master), .cfg_fault_en(cfg_fault_en), .cfg_ss_drive(cfg_ss_drive),
  .ss_in_n(ss_in_n), .flush(flush), .rx_full(rx_full), .match_flag(match_flag),
  .fault_flag(fault_flag)
);

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb;
  localparam int CLK_P = 10;
  localparam int D     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, rx_valid = 1'b0, bus_rd_status = 1'b0, bus_rd_data = 1'b0;
  logic bus_wr_status = 1'b0, bus_wr_ctrl = 1'b0, fifo_mode = 1'b0;
  logic cfg_master = 1'b0, cfg_fault_en = 1'b0, cfg_ss_drive = 1'b0, ss_in_n = 1'b1;
  logic [15:0] rx_data = '0, match_val = '0;
  logic [7:0]  bus_wdata = '0;
  logic rx_full, match_flag, fault_flag;
  logic [15:0] rd_data;

  int checks = 0, errors = 0;

  logic [15:0] m_q [D];
  int m_cnt;
  logic m_mode, m_full, m_mat, m_marm, m_flt, m_farm;

  always #(CLK_P/2) clk = ~clk;

  spi_rx_status u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .bus_rd_status(bus_rd_status), .bus_rd_data(bus_rd_data),
    .bus_wr_status(bus_wr_status), .bus_wdata(bus_wdata), .bus_wr_ctrl(bus_wr_ctrl),
    .match_val(match_val), .fifo_mode(fifo_mode), .cfg_master(cfg_master),
    .cfg_fault_en(cfg_fault_en), .cfg_ss_drive(cfg_ss_drive), .ss_in_n(ss_in_n),
    .rx_full(rx_full), .match_flag(match_flag), .fault_flag(fault_flag),
    .rd_data(rd_data)
  );

  function automatic bit fault_cond();
    return cfg_master && cfg_fault_en && !cfg_ss_drive && !ss_in_n;
  endfunction

  task automatic model_step();
    bit set, mset, fc;
    set = 0;
    fc  = fault_cond();
    if (!rst_n) begin
      for (int i = 0; i < D; i++) m_q[i] = '0;
      m_cnt = 0; m_mode = fifo_mode; m_full = 0;
      m_mat = 0; m_marm = 0; m_flt = 0; m_farm = 0;
      return;
    end
    if (fifo_mode != m_mode) begin
      for (int i = 0; i < D; i++) m_q[i] = '0;
      m_cnt = 0; m_full = 0;
    end else if (!fifo_mode) begin
      if (rx_valid) begin m_q[0] = rx_data; m_cnt = 1; set = 1; end
      else if (bus_rd_data) m_cnt = 0;
      m_full = set ? 1'b1 : bus_rd_data ? 1'b0 : m_full;
    end else begin
      bit popped;
      popped = bus_rd_data && m_cnt > 0;
      if (popped) begin
        for (int i = 0; i < D-1; i++) m_q[i] = m_q[i+1];
        m_q[D-1] = '0; m_cnt--;
      end
      if (rx_valid && m_cnt < D) begin
        m_q[m_cnt] = rx_data; m_cnt++; set = (m_cnt == D);
      end
      m_full = set ? 1'b1 : bus_rd_data ? 1'b0 : m_full;
    end
    m_mode = fifo_mode;
    mset = set && rx_data == match_val;
    if (mset) m_mat = 1;
    else if (bus_wr_status && bus_wdata[6] && m_marm) m_mat = 0;
    m_marm = mset ? 1'b0 : (bus_rd_status && m_mat_prev) ? 1'b1 : bus_wr_status ? 1'b0 : m_marm;
    if (fc) m_flt = 1;
    else if (bus_wr_ctrl && m_farm) m_flt = 0;
    m_farm = fc ? 1'b0 : (bus_rd_status && m_flt_prev) ? 1'b1 : bus_wr_ctrl ? 1'b0 : m_farm;
  endtask

  logic m_mat_prev, m_flt_prev;

  task automatic check_all(input string tag);
    checks++;
    if (rx_full !== m_full || match_flag !== m_mat || fault_flag !== m_flt ||
        rd_data !== m_q[0]) begin
      errors++;
      $display("FAIL %s: full/match/fault/data actual=%b%b%b/%h expected=%b%b%b/%h",
               tag, rx_full, match_flag, fault_flag, rd_data, m_full, m_mat, m_flt, m_q[0]);
    end
  endtask

  task automatic step(input string tag);
    m_mat_prev = m_mat;
    m_flt_prev = m_flt;
    model_step();
    @(negedge clk);
    check_all(tag);
    rx_valid = 0; bus_rd_status = 0; bus_rd_data = 0; bus_wr_status = 0;
    bus_wr_ctrl = 0; bus_wdata = '0;
  endtask

  task automatic push(input logic [15:0] w, input string tag);
    rx_valid = 1; rx_data = w; step(tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_mat = 0; m_flt = 0;
    rst_n = 0; step("R1 reset"); step("R1 reset");
    rst_n = 1;
    // R2 single buffer
    push(16'h1234, "R2 first word");
    push(16'hBEEF, "R2 overwrite");
    bus_rd_data = 1; step("R3 read clears");
    push(16'h0F0F, "R2 refill");
    bus_rd_data = 1; rx_valid = 1; rx_data = 16'h7777; step("R3 read with arrival");
    // R11 flush on mode change
    fifo_mode = 1; step("R11 flush");
    // R4 fill
    push(16'hA001, "R4 one"); push(16'hA002, "R4 two"); push(16'hA003, "R4 three");
    push(16'hA004, "R4 fourth sets");
    push(16'hA005, "R5 drop when full");
    bus_rd_data = 1; step("R4 pop oldest");
    push(16'hA006, "R4 refill");
    for (int k = 0; k < 5; k++) begin bus_rd_data = 1; step("R4 drain order"); end
    fifo_mode = 0; push(16'h5555, "R11 arrival ignored on flip");
    // R6 match
    match_val = 16'h00A5;
    push(16'h1111, "R6 no match");
    push(16'h00A5, "R6 match sets");
    bus_wr_status = 1; bus_wdata = 8'h40; step("R7 write without read");
    bus_rd_status = 1; step("R7 arm");
    bus_wr_status = 1; bus_wdata = 8'h00; step("R7 wrong bit");
    bus_wr_status = 1; bus_wdata = 8'h40; step("R7 arm consumed");
    bus_rd_status = 1; step("R8 arm");
    push(16'h00A5, "R8 set between");
    bus_wr_status = 1; bus_wdata = 8'h40; step("R8 write ignored");
    bus_rd_status = 1; step("R7 arm again");
    bus_wr_status = 1; bus_wdata = 8'h40; step("R7 clears");
    // R9 configuration sweep
    for (int c = 0; c < 32; c++) begin
      {ss_in_n, cfg_master, cfg_fault_en, cfg_ss_drive} = c[3:0];
      step("R9 sweep");
      if (fault_flag) begin
        ss_in_n = 1; bus_rd_status = 1; step("R10 arm");
        bus_wr_ctrl = 1; step("R10 clear");
      end
    end
    cfg_master = 1; cfg_fault_en = 1; cfg_ss_drive = 0; ss_in_n = 0; step("R9 set");
    ss_in_n = 1; bus_wr_ctrl = 1; step("R10 write without read");
    ss_in_n = 0; bus_rd_status = 1; step("R10 read while held");
    bus_wr_ctrl = 1; step("R10 condition holds");
    ss_in_n = 1; bus_rd_status = 1; step("R10 arm");
    bus_wr_ctrl = 1; step("R10 clears");
    // random
    for (int n = 0; n < 6000; n++) begin
      rst_n         = ($urandom_range(199) != 0);
      rx_valid      = ($urandom_range(2) == 0);
      rx_data       = ($urandom_range(3) == 0) ? match_val : 16'($urandom_range(15));
      bus_rd_status = ($urandom_range(2) == 0);
      bus_rd_data   = ($urandom_range(3) == 0);
      bus_wr_status = ($urandom_range(4) == 0);
      bus_wdata     = 8'($urandom_range(255));
      bus_wr_ctrl   = ($urandom_range(4) == 0);
      if ($urandom_range(99) == 0) fifo_mode = ~fifo_mode;
      if ($urandom_range(49) == 0) match_val = 16'($urandom_range(15));
      cfg_master    = ($urandom_range(3) != 0);
      cfg_fault_en  = ($urandom_range(3) != 0);
      cfg_ss_drive  = ($urandom_range(3) == 0);
      ss_in_n       = ($urandom_range(9) != 0);
      step("R2 R4 R6 R9 random");
    end
    rst_n = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule